// File: doc/BRIEF.md
# Dispatch Steering with Barrier Chaining

This block sits between a front-end instruction queue and the out-of-order back end. Each cycle it looks at up to a dispatch width of decoded instruction descriptors, oldest in slot 0. It takes them in order and gives every live one a reorder-buffer slot. It then sends each one to exactly one destination: the execute-ready queue, the waiting list, or straight to commit-ready when it is a no-op. Dispatch stops for the rest of the cycle at the first slot that cannot be taken.

Memory ordering is tracked with a single register that holds the sequence number of the youngest memory barrier still outstanding. A newly dispatched barrier, or a memory operation that must wait behind a barrier, is reported as a dependency link whose parent is that register's value. When several such instructions arrive in one cycle, the parent is the youngest barrier seen so far in that cycle. The block also counts how many entries are on the waiting list and how many of those are memory operations. An outside consumer reports departures from the waiting list, and the block subtracts them from the counts.

Top module: `dsp_steer`

## Requirements
- R1: A slot is taken only while the reorder-buffer occupancy (`robUsed` plus live slots already taken this cycle) is below `ROB_DEPTH`. Once the limit is reached, no later slot is taken in that cycle.
- R2: A slot is taken only while the waiting-memory count (`waitMemCount` plus memory operations placed on the waiting list earlier in the cycle) is below `MAX_MEM_WAIT`. Once the limit is reached, no later slot is taken in that cycle.
- R3: When `limitEn` is 1 and `lsqFull` is 1, no slot is taken. When `limitEn` is 0, `lsqFull` has no effect on dispatch.
- R4: A valid slot with `inSquash` set is consumed and counted in `popCount`. It takes no reorder-buffer slot, drives no push, mark or link, and the next slot is still considered.
- R5: A barrier slot (`inBarrier`) is marked commit-ready and becomes the youngest barrier. If a barrier was already outstanding, the slot raises `linkValid` with `linkParent` equal to that barrier's sequence number. `linkParent` is zero wherever `linkValid` is low. Barrier takes priority over every other class flag.
- R6: A ready, speculative (neither `inNonSpec` nor `inStoreCond`) non-memory slot is pushed to the execute queue. If it is a no-op (`inNop`), it instead raises `nopFinish` and `commitMark` and is counted in `wbTally`. The memory flag takes precedence over the no-op flag.
- R7: A ready, speculative memory slot raises `lsqPush`. If a barrier is outstanding, it also raises a link and `waitPush` and counts as a waiting memory operation. Otherwise it is pushed to the execute queue.
- R8: A slot that is not ready, or is non-speculative or store-conditional, goes to the waiting list. Non-speculative and store-conditional slots also raise `commitMark`. A memory slot on this path also raises `lsqPush`, counts as a waiting memory operation, and is linked if a barrier is outstanding.
- R9: Each clock, `waitCount` gains the number of `waitPush` bits and loses `waitLeave`. `waitMemCount` gains the number of waiting memory operations and loses `memLeave`.
- R10: With `DISPATCH_WIDTH` set to 0, the dispatch width equals `MACHINE_WIDTH`, so four slots can be taken in one cycle by default.
- R11: A synchronous reset clears `waitCount`, `waitMemCount` and `youngValid`.
- R12: `barRetire` with `barRetireSeq` equal to `youngSeq` clears `youngValid` on the next clock, unless a barrier is dispatched in the same cycle. In that case the new barrier becomes the youngest.
- R13: Dispatch is in slot order. An invalid slot ends dispatch for the cycle even if later slots are valid. `popCount` equals the number of consumed slots, squashed ones included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| limitEn | input | 1 | Lets a full load/store queue stall dispatch |
| lsqFull | input | 1 | Load/store queue is full |
| robUsed | input | ROB_W | Current reorder-buffer occupancy |
| inValid | input | DW | Slot i holds an instruction (bit i) |
| inSquash | input | DW | Slot i already squashed |
| inBarrier | input | DW | Slot i is a memory barrier |
| inMem | input | DW | Slot i is a memory operation |
| inNop | input | DW | Slot i is a no-op |
| inReady | input | DW | Slot i has all operands ready |
| inNonSpec | input | DW | Slot i must execute non-speculatively |
| inStoreCond | input | DW | Slot i is a store-conditional |
| inSeq | input | DW*SEQ_W | Slot i sequence number in bits [i*SEQ_W +: SEQ_W] |
| waitLeave | input | CNT_W | Entries leaving the waiting list this cycle |
| memLeave | input | CNT_W | Memory operations leaving the waiting list this cycle |
| barRetire | input | 1 | A barrier has retired |
| barRetireSeq | input | SEQ_W | Sequence number of the retired barrier |
| popCount | output | PW | Slots consumed from the front-end queue |
| exePush | output | DW | Push slot i to the execute queue |
| waitPush | output | DW | Put slot i on the waiting list |
| lsqPush | output | DW | Insert slot i into the load/store queue |
| commitMark | output | DW | Mark slot i commit-ready |
| nopFinish | output | DW | Mark slot i issued and executed |
| linkValid | output | DW | Slot i becomes dependent of a barrier |
| linkParent | output | DW*SEQ_W | Parent barrier sequence for slot i |
| wbTally | output | PW | No-ops counted toward writeback this cycle |
| waitCount | output | CNT_W | Waiting-list occupancy |
| waitMemCount | output | CNT_W | Waiting memory operations |
| youngValid | output | 1 | A barrier is outstanding |
| youngSeq | output | SEQ_W | Sequence number of the youngest barrier |

## Verification
Every cycle, the assertions check four things: the reorder-buffer and waiting-memory caps, the all-stop under a full load/store queue, the clean discard of squashed slots, and the one-destination rule per slot. They also check that every link has an outstanding parent, and that a dispatched or retired barrier updates the youngest-barrier register on the next clock. Some properties depend on the whole cycle's sequence of slots. These are the exact routing class of each slot, the parent value chained through several barriers in one cycle, in-order stopping at an invalid slot, and counter arithmetic across departures. Only the bench's reference model, compared on every clock over directed and random slot mixes, can show these.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
  // Per-slot decision flags passed from control to datapath
  typedef struct packed {
    logic take;     // consumed from the front-end queue
    logic alloc;    // holds a reorder-buffer slot
    logic exe;      // execute queue
    logic toWait;   // waiting list
    logic memWait;  // counts as a waiting memory op
    logic lsq;      // load/store queue insert
    logic commit;   // commit-ready mark
    logic nop;      // finished no-op
    logic link;     // dependent of the youngest barrier
    logic bar;      // is a barrier
  } slotStrobe_t;
endpackage

// File: rtl/dsp_ctrl.sv
module dsp_ctrl
  import dsp_pkg::*;
#(
  parameter int DW = 4,
  parameter int ROB_DEPTH = 16,
  parameter int MAX_MEM_WAIT = 4,
  parameter int CNT_W = 8,
  parameter int ROB_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic limitEn,
  input  logic lsqFull,
  input  logic [ROB_W-1:0] robUsed,
  input  logic [DW-1:0] inValid,
  input  logic [DW-1:0] inSquash,
  input  logic [DW-1:0] inBarrier,
  input  logic [DW-1:0] inMem,
  input  logic [DW-1:0] inNop,
  input  logic [DW-1:0] inReady,
  input  logic [DW-1:0] inNonSpec,
  input  logic [DW-1:0] inStoreCond,
  input  logic [CNT_W-1:0] waitMemCount,
  input  logic barValid,
  output slotStrobe_t [DW-1:0] st
);
  localparam logic [ROB_W:0] ROB_LIM = (ROB_W+1)'(ROB_DEPTH);
  localparam logic [CNT_W:0] MEM_LIM = (CNT_W+1)'(MAX_MEM_WAIT);
  localparam logic [ROB_W:0] ONE_R = 1;
  localparam logic [CNT_W:0] ONE_M = 1;

  logic [ROB_W:0] robAcc;
  logic [CNT_W:0] memAcc;
  logic halt;
  logic barPres;

  always_comb begin
    robAcc = {1'b0, robUsed};
    memAcc = {1'b0, waitMemCount};
    halt = limitEn & lsqFull;
    barPres = barValid;
    st = '0;
    for (int i = 0; i < DW; i++) begin
      if (!halt) begin
        if (robAcc >= ROB_LIM || memAcc >= MEM_LIM || !inValid[i]) begin
          halt = 1'b1;
        end else if (inSquash[i]) begin
          st[i].take = 1'b1;
        end else begin
          st[i].take = 1'b1;
          st[i].alloc = 1'b1;
          robAcc = robAcc + ONE_R;
          if (inBarrier[i]) begin
            st[i].link = barPres;
            st[i].bar = 1'b1;
            st[i].commit = 1'b1;
            barPres = 1'b1;
          end else if (inReady[i] && !inNonSpec[i] && !inStoreCond[i]) begin
            if (inMem[i]) begin
              st[i].lsq = 1'b1;
              if (barPres) begin
                st[i].link = 1'b1;
                st[i].toWait = 1'b1;
                st[i].memWait = 1'b1;
              end else begin
                st[i].exe = 1'b1;
              end
            end else if (inNop[i]) begin
              st[i].nop = 1'b1;
              st[i].commit = 1'b1;
            end else begin
              st[i].exe = 1'b1;
            end
          end else begin
            st[i].toWait = 1'b1;
            st[i].commit = inNonSpec[i] | inStoreCond[i];
            if (inMem[i]) begin
              st[i].lsq = 1'b1;
              st[i].memWait = 1'b1;
              st[i].link = barPres;
            end
          end
          if (st[i].memWait) memAcc = memAcc + ONE_M;
        end
      end
    end
  end

  logic [DW-1:0] allocVec;
  logic [DW-1:0] takeVec;
  for (genvar g = 0; g < DW; g++) begin : g_vec
    assign allocVec[g] = st[g].alloc;
    assign takeVec[g] = st[g].take;

    // R4: a discarded squashed slot drives nothing else
    a_r4_squash_clean: assert property (@(posedge clk) disable iff (rst)
      (st[g].take && inSquash[g]) |->
        !(st[g].alloc || st[g].exe || st[g].toWait || st[g].lsq || st[g].commit || st[g].nop || st[g].link));

    // R7: at most one destination per slot
    a_r7_one_route: assert property (@(posedge clk) disable iff (rst)
      $onehot0({st[g].exe, st[g].toWait, st[g].nop}));
  end

  // R1: allocations never push occupancy past capacity
  a_r1_rob_cap: assert property (@(posedge clk) disable iff (rst)
    (int'(robUsed) <= ROB_DEPTH) |-> (int'(robUsed) + $countones(allocVec) <= ROB_DEPTH));

  // R3: a full load/store queue under limitEn stops all dispatch
  a_r3_lsq_halt: assert property (@(posedge clk) disable iff (rst)
    (limitEn && lsqFull) |-> (takeVec == '0));
endmodule

// File: rtl/dsp_data.sv
module dsp_data
  import dsp_pkg::*;
#(
  parameter int DW = 4,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 8,
  parameter int MAX_MEM_WAIT = 4,
  parameter int PW = 3
) (
  input  logic clk,
  input  logic rst,
  input  slotStrobe_t [DW-1:0] st,
  input  logic [DW*SEQ_W-1:0] inSeq,
  input  logic [CNT_W-1:0] waitLeave,
  input  logic [CNT_W-1:0] memLeave,
  input  logic barRetire,
  input  logic [SEQ_W-1:0] barRetireSeq,
  output logic [PW-1:0] popCount,
  output logic [DW-1:0] exePush,
  output logic [DW-1:0] waitPush,
  output logic [DW-1:0] lsqPush,
  output logic [DW-1:0] commitMark,
  output logic [DW-1:0] nopFinish,
  output logic [DW-1:0] linkValid,
  output logic [DW*SEQ_W-1:0] linkParent,
  output logic [PW-1:0] wbTally,
  output logic [CNT_W-1:0] waitCount,
  output logic [CNT_W-1:0] waitMemCount,
  output logic barValid,
  output logic [SEQ_W-1:0] barSeq
);
  localparam logic [PW-1:0] ONE_P = 1;
  localparam logic [CNT_W-1:0] ONE_C = 1;
  localparam logic [CNT_W-1:0] MEM_CAP = CNT_W'(MAX_MEM_WAIT);

  logic [CNT_W-1:0] addW;
  logic [CNT_W-1:0] addM;
  logic [SEQ_W-1:0] chainS;
  logic chainV;
  logic anyBar;
  logic [DW-1:0] chainBefore;

  always_comb begin
    chainV = barValid;
    chainS = barSeq;
    anyBar = 1'b0;
    addW = '0;
    addM = '0;
    popCount = '0;
    wbTally = '0;
    linkParent = '0;
    chainBefore = '0;
    for (int i = 0; i < DW; i++) begin
      exePush[i] = st[i].exe;
      waitPush[i] = st[i].toWait;
      lsqPush[i] = st[i].lsq;
      commitMark[i] = st[i].commit;
      nopFinish[i] = st[i].nop;
      linkValid[i] = st[i].link;
      chainBefore[i] = chainV;
      if (st[i].link) linkParent[i*SEQ_W +: SEQ_W] = chainS;
      if (st[i].bar) begin
        chainV = 1'b1;
        chainS = inSeq[i*SEQ_W +: SEQ_W];
        anyBar = 1'b1;
      end
      if (st[i].take) popCount = popCount + ONE_P;
      if (st[i].nop) wbTally = wbTally + ONE_P;
      if (st[i].toWait) addW = addW + ONE_C;
      if (st[i].memWait) addM = addM + ONE_C;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waitCount <= '0;
      waitMemCount <= '0;
      barValid <= 1'b0;
      barSeq <= '0;
    end else begin
      waitCount <= waitCount + addW - waitLeave;
      waitMemCount <= waitMemCount + addM - memLeave;
      if (anyBar) begin
        barValid <= 1'b1;
        barSeq <= chainS;
      end else if (barRetire && barValid && barRetireSeq == barSeq) begin
        barValid <= 1'b0;
      end
    end
  end

  logic [DW-1:0] barVec;
  for (genvar g = 0; g < DW; g++) begin : g_chk
    assign barVec[g] = st[g].bar;
    // R5: every link has an outstanding parent barrier
    a_r5_link_parent: assert property (@(posedge clk) disable iff (rst)
      st[g].link |-> chainBefore[g]);
  end

  // R5: a dispatched barrier is outstanding on the next clock
  a_r5_bar_young: assert property (@(posedge clk) disable iff (rst)
    (|barVec) |=> barValid);

  // R2: waiting memory ops stay within the configured maximum
  a_r2_mem_cap: assert property (@(posedge clk) disable iff (rst)
    waitMemCount <= MEM_CAP);

  // R12: a matching retirement without a new barrier clears the register
  a_r12_retire: assert property (@(posedge clk) disable iff (rst)
    (barRetire && barValid && barRetireSeq == barSeq && !(|barVec)) |=> !barValid);
endmodule

// File: rtl/dsp_steer.sv
module dsp_steer
  import dsp_pkg::*;
#(
  parameter int MACHINE_WIDTH = 4,
  parameter int DISPATCH_WIDTH = 0,
  parameter int ROB_DEPTH = 16,
  parameter int MAX_MEM_WAIT = 4,
  parameter int SEQ_W = 8,
  parameter int CNT_W = 8,
  localparam int DW = (DISPATCH_WIDTH == 0) ? MACHINE_WIDTH : DISPATCH_WIDTH,
  localparam int ROB_W = $clog2(ROB_DEPTH + 1),
  localparam int PW = $clog2(DW + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic limitEn,
  input  logic lsqFull,
  input  logic [ROB_W-1:0] robUsed,
  input  logic [DW-1:0] inValid,
  input  logic [DW-1:0] inSquash,
  input  logic [DW-1:0] inBarrier,
  input  logic [DW-1:0] inMem,
  input  logic [DW-1:0] inNop,
  input  logic [DW-1:0] inReady,
  input  logic [DW-1:0] inNonSpec,
  input  logic [DW-1:0] inStoreCond,
  input  logic [DW*SEQ_W-1:0] inSeq,
  input  logic [CNT_W-1:0] waitLeave,
  input  logic [CNT_W-1:0] memLeave,
  input  logic barRetire,
  input  logic [SEQ_W-1:0] barRetireSeq,
  output logic [PW-1:0] popCount,
  output logic [DW-1:0] exePush,
  output logic [DW-1:0] waitPush,
  output logic [DW-1:0] lsqPush,
  output logic [DW-1:0] commitMark,
  output logic [DW-1:0] nopFinish,
  output logic [DW-1:0] linkValid,
  output logic [DW*SEQ_W-1:0] linkParent,
  output logic [PW-1:0] wbTally,
  output logic [CNT_W-1:0] waitCount,
  output logic [CNT_W-1:0] waitMemCount,
  output logic youngValid,
  output logic [SEQ_W-1:0] youngSeq
);
  slotStrobe_t [DW-1:0] strobes;

  dsp_ctrl #(
    .DW(DW), .ROB_DEPTH(ROB_DEPTH), .MAX_MEM_WAIT(MAX_MEM_WAIT),
    .CNT_W(CNT_W), .ROB_W(ROB_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .limitEn(limitEn), .lsqFull(lsqFull),
    .robUsed(robUsed), .inValid(inValid), .inSquash(inSquash),
    .inBarrier(inBarrier), .inMem(inMem), .inNop(inNop),
    .inReady(inReady), .inNonSpec(inNonSpec), .inStoreCond(inStoreCond),
    .waitMemCount(waitMemCount), .barValid(youngValid), .st(strobes)
  );

  dsp_data #(
    .DW(DW), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .MAX_MEM_WAIT(MAX_MEM_WAIT), .PW(PW)
  ) u_data (
    .clk(clk), .rst(rst), .st(strobes), .inSeq(inSeq),
    .waitLeave(waitLeave), .memLeave(memLeave),
    .barRetire(barRetire), .barRetireSeq(barRetireSeq),
    .popCount(popCount), .exePush(exePush), .waitPush(waitPush),
    .lsqPush(lsqPush), .commitMark(commitMark), .nopFinish(nopFinish),
    .linkValid(linkValid), .linkParent(linkParent), .wbTally(wbTally),
    .waitCount(waitCount), .waitMemCount(waitMemCount),
    .barValid(youngValid), .barSeq(youngSeq)
  );
endmodule

// File: tb/sim_dsp_steer.sv
module sim_dsp_steer;
  localparam int PERIOD = 10;
  localparam int NS = 4;
  localparam int ROBD = 16;
  localparam int MAXM = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic limitEn = 1'b0, lsqFull = 1'b0;
  logic [4:0] robUsed = '0;
  logic [NS-1:0] inValid = '0, inSquash = '0, inBarrier = '0, inMem = '0;
  logic [NS-1:0] inNop = '0, inReady = '0, inNonSpec = '0, inStoreCond = '0;
  logic [NS*8-1:0] inSeq = '0;
  logic [7:0] waitLeave = '0, memLeave = '0;
  logic barRetire = 1'b0;
  logic [7:0] barRetireSeq = '0;
  logic [2:0] popCount, wbTally;
  logic [NS-1:0] exePush, waitPush, lsqPush, commitMark, nopFinish, linkValid;
  logic [NS*8-1:0] linkParent;
  logic [7:0] waitCount, waitMemCount, youngSeq;
  logic youngValid;

  dsp_steer u0 (
    .clk(clk), .rst(rst), .limitEn(limitEn), .lsqFull(lsqFull), .robUsed(robUsed),
    .inValid(inValid), .inSquash(inSquash), .inBarrier(inBarrier), .inMem(inMem),
    .inNop(inNop), .inReady(inReady), .inNonSpec(inNonSpec), .inStoreCond(inStoreCond),
    .inSeq(inSeq), .waitLeave(waitLeave), .memLeave(memLeave),
    .barRetire(barRetire), .barRetireSeq(barRetireSeq),
    .popCount(popCount), .exePush(exePush), .waitPush(waitPush), .lsqPush(lsqPush),
    .commitMark(commitMark), .nopFinish(nopFinish), .linkValid(linkValid),
    .linkParent(linkParent), .wbTally(wbTally), .waitCount(waitCount),
    .waitMemCount(waitMemCount), .youngValid(youngValid), .youngSeq(youngSeq)
  );

  always #(PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  int seqNext = 1;

  // reference state
  int mWait = 0, mWaitMem = 0, mBarV = 0, mBarS = 0;
  // expectations for the current cycle
  int ePop, eWb, eAddW, eAddM, eNewBar, eNewBarS;
  bit [NS-1:0] eExe, eWait, eLsq, eCom, eNop, eLink;
  int eParent [NS];

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model();
    int rob = int'(robUsed);
    int mem = mWaitMem;
    bit halt = limitEn && lsqFull;
    int bp = mBarV;
    int bs = mBarS;
    ePop = 0; eWb = 0; eAddW = 0; eAddM = 0; eNewBar = 0;
    eExe = '0; eWait = '0; eLsq = '0; eCom = '0; eNop = '0; eLink = '0;
    for (int i = 0; i < NS; i++) begin
      eParent[i] = 0;
      if (halt) continue;
      if (rob >= ROBD || mem >= MAXM || !inValid[i]) begin halt = 1; continue; end
      ePop++;
      if (inSquash[i]) continue;
      rob++;
      if (inBarrier[i]) begin
        if (bp != 0) begin eLink[i] = 1; eParent[i] = bs; end
        eCom[i] = 1; bp = 1; bs = int'(inSeq[i*8 +: 8]); eNewBar = 1;
      end else if (inReady[i] && !inNonSpec[i] && !inStoreCond[i]) begin
        if (inMem[i]) begin
          eLsq[i] = 1;
          if (bp != 0) begin
            eLink[i] = 1; eParent[i] = bs; eWait[i] = 1; eAddW++; eAddM++; mem++;
          end else eExe[i] = 1;
        end else if (inNop[i]) begin
          eNop[i] = 1; eCom[i] = 1; eWb++;
        end else eExe[i] = 1;
      end else begin
        eWait[i] = 1; eAddW++;
        eCom[i] = inNonSpec[i] | inStoreCond[i];
        if (inMem[i]) begin
          eLsq[i] = 1; eAddM++; mem++;
          if (bp != 0) begin eLink[i] = 1; eParent[i] = bs; end
        end
      end
    end
    eNewBarS = bs;
  endtask

  task automatic compareAll();
    model();
    chk("R1 R2 R3 R4 R13 popCount", int'(popCount), ePop);
    chk("R6 R7 exePush", int'(exePush), int'(eExe));
    chk("R7 R8 waitPush", int'(waitPush), int'(eWait));
    chk("R7 R8 lsqPush", int'(lsqPush), int'(eLsq));
    chk("R5 R6 R8 commitMark", int'(commitMark), int'(eCom));
    chk("R6 nopFinish", int'(nopFinish), int'(eNop));
    chk("R6 wbTally", int'(wbTally), eWb);
    chk("R5 linkValid", int'(linkValid), int'(eLink));
    for (int i = 0; i < NS; i++)
      chk("R5 linkParent", int'(linkParent[i*8 +: 8]), eParent[i]);
    chk("R9 waitCount", int'(waitCount), mWait);
    chk("R9 waitMemCount", int'(waitMemCount), mWaitMem);
    chk("R12 youngValid", int'(youngValid), mBarV);
    if (mBarV != 0) chk("R5 youngSeq", int'(youngSeq), mBarS);
  endtask

  // drive at negedge, compare 1 time unit later, update the model at the edge
  task automatic step();
    #1;
    compareAll();
    @(posedge clk);
    mWait = (mWait + eAddW - int'(waitLeave)) & 255;
    mWaitMem = (mWaitMem + eAddM - int'(memLeave)) & 255;
    if (eNewBar != 0) begin mBarV = 1; mBarS = eNewBarS; end
    else if (barRetire && int'(barRetireSeq) == mBarS) mBarV = 0;
    @(negedge clk);
  endtask

  task automatic clearIn();
    inValid = '0; inSquash = '0; inBarrier = '0; inMem = '0; inNop = '0;
    inReady = '0; inNonSpec = '0; inStoreCond = '0;
    waitLeave = '0; memLeave = '0; barRetire = 1'b0; robUsed = '0;
    limitEn = 1'b0; lsqFull = 1'b0;
    for (int i = 0; i < NS; i++) begin
      inSeq[i*8 +: 8] = 8'(seqNext); seqNext = (seqNext + 1) & 255;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clearIn();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11 waitCount", int'(waitCount), 0);
    chk("R11 waitMemCount", int'(waitMemCount), 0);
    chk("R11 youngValid", int'(youngValid), 0);
    rst = 1'b0;

    // R10: four plain ready slots dispatch in one cycle
    clearIn(); inValid = 4'hF; inReady = 4'hF;
    #1; chk("R10 width", int'(popCount), 4); #1;
    step();

    // R5 R7 R6: barrier, ready mem behind it, plain, nop
    clearIn(); inValid = 4'hF; inReady = 4'hE; inBarrier = 4'h1; inMem = 4'h2; inNop = 4'h8;
    step();
    // R5: second barrier chains to the first, then mem links to the new one
    clearIn(); inValid = 4'h3; inBarrier = 4'h1; inMem = 4'h2; inReady = 4'h2;
    step();
    // R12: retire the youngest barrier
    clearIn(); barRetire = 1'b1; barRetireSeq = youngSeq;
    step();
    // R8: not-ready, nonspec, store-conditional, not-ready mem
    clearIn(); inValid = 4'hF; inReady = 4'h6; inNonSpec = 4'h2; inStoreCond = 4'h4; inMem = 4'h8;
    waitLeave = 8'(mWait);
    step();
    // R4 R13: squashed slot skipped, invalid slot stops
    clearIn(); inValid = 4'hB; inSquash = 4'h2; inReady = 4'hF;
    step();
    // R1: one free ROB entry
    clearIn(); inValid = 4'hF; inReady = 4'hF; robUsed = 5'd15;
    step();
    // R3: lsq full with and without limitEn
    clearIn(); inValid = 4'hF; inReady = 4'hF; limitEn = 1'b1; lsqFull = 1'b1;
    #1; chk("R3 halt", int'(popCount), 0); #1;
    step();
    clearIn(); inValid = 4'hF; inReady = 4'hF; lsqFull = 1'b1;
    step();
    // R2: fill waiting memory ops up to the cap
    clearIn(); inValid = 4'hF; inMem = 4'hF; memLeave = 8'(mWaitMem); waitLeave = 8'(mWait);
    step();
    clearIn(); inValid = 4'hF; inMem = 4'hF;
    step();

    // random mix
    for (int n = 0; n < 600; n++) begin
      clearIn();
      for (int i = 0; i < NS; i++) begin
        inValid[i] = ($urandom_range(0, 99) < 85);
        inSquash[i] = ($urandom_range(0, 99) < 10);
        inBarrier[i] = ($urandom_range(0, 99) < 10);
        inMem[i] = ($urandom_range(0, 99) < 35);
        inNop[i] = ($urandom_range(0, 99) < 15);
        inReady[i] = ($urandom_range(0, 99) < 70);
        inNonSpec[i] = ($urandom_range(0, 99) < 10);
        inStoreCond[i] = ($urandom_range(0, 99) < 5);
      end
      robUsed = ($urandom_range(0, 3) == 0) ? 5'($urandom_range(13, 16)) : 5'($urandom_range(0, 12));
      limitEn = $urandom_range(0, 1) == 1;
      lsqFull = $urandom_range(0, 3) == 0;
      waitLeave = 8'($urandom_range(0, mWait));
      memLeave = 8'($urandom_range(0, mWaitMem));
      barRetire = $urandom_range(0, 4) == 0;
      barRetireSeq = ($urandom_range(0, 9) < 7) ? 8'(mBarS) : 8'($urandom_range(0, 255));
      step();
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule